// File: doc/BRIEF.md
# Synchronous Serial Slave Transmitter

This block sends bytes over a clocked serial link in which a remote master owns the shift clock. The local processor hands over bytes through a one-cycle write strobe. The block places them on a serial data line, least significant bit first. The line advances one bit on each falling edge of the external clock. The external clock is brought into the system clock domain through a two-flop synchronizer, and its edges are detected there. All state runs on the system clock.

A run-time mode input selects how writes are staged. In single-buffer mode a write lands directly in the shift stage. In double-buffer mode a holding register sits in front of the shift stage, so software can stay one byte ahead of the line. A buffer-empty flag and a one-cycle interrupt pulse tell software when another byte can be written.

If the master starts a byte while no data is staged, the block still clocks out eight bits. It sends all ones in that case and raises a sticky underrun flag, which software clears with a dedicated clear input.

Top module: `sst_tx`

## Requirements
- R1: After reset, txd_o is 1, buf_empty_o is 1, tx_irq_o is 0 and underrun_o is 0.
- R2: A staged byte is sent least significant bit first. Bit 0 appears after the first falling edge of sclk_i, and each further falling edge presents the next bit, for eight bits in total.
- R3: While no byte is being shifted, including after the rising sclk_i edge that ends the eighth bit, txd_o is held at 1.
- R4: In single-buffer mode (dbuf_en_i = 0), tx_irq_o pulses for one cycle when the rising sclk_i edge ending the eighth bit is seen.
- R5: In double-buffer mode (dbuf_en_i = 1), a write that finds the shifter idle with nothing staged moves straight into the shift stage. This raises one tx_irq_o pulse and leaves buf_empty_o at 1.
- R6: In double-buffer mode, a write that cannot go straight to the shift stage waits in the holding register and clears buf_empty_o. When the current byte completes, the held byte moves to the shift stage, buf_empty_o returns to 1, one tx_irq_o pulse is raised, and the held byte is the next one sent. A completion with an empty holding register raises no pulse.
- R7: If a transfer starts with nothing staged, the byte sent is 0xFF and underrun_o is set.
- R8: underrun_o stays set until err_clr_i is asserted. A new underrun in the same cycle as a clear keeps the flag set.
- R9: In single-buffer mode, a write while the shifter is idle clears buf_empty_o, and the start of the transfer that consumes the byte sets it again.
- R10: dbuf_en_i may change between bytes, and each write is handled under the mode in force in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | One-cycle byte write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| dbuf_en_i | input | 1 | 1 selects double-buffer mode, 0 single-buffer mode |
| err_clr_i | input | 1 | Clears the underrun flag |
| sclk_i | input | 1 | External shift clock, idle high, asynchronous |
| txd_o | output | 1 | Serial data output |
| buf_empty_o | output | 1 | Write buffer empty flag |
| tx_irq_o | output | 1 | One-cycle transmit interrupt pulse |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench captures each byte bit by bit on the rising sclk edges, then compares the assembled value. A design that sent MSB first or skipped the first bit would return a mirrored or shifted byte. It counts interrupt pulses per byte in both modes. An interrupt missing on the direct move, or a spurious one on a completion with nothing held, shows up as a wrong count. A double-buffer chain of two writes checks that the second byte waits with the empty flag low and is sent next. A design that overwrote the shift stage would send the second byte twice or lose the first. Transfers started with nothing staged must yield 0xFF and an underrun flag that survives idle time until it is cleared.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYNC_STAGES = 2;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t FILL_BYTE = '1;
endpackage

// File: rtl/sst_sclk_sync.sv
module sst_sclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-1:0], sclk_i};
  end

  assign fall_o = sync_q[STAGES] & ~sync_q[STAGES-1];
  assign rise_o = ~sync_q[STAGES] & sync_q[STAGES-1];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fall_i,
  input  logic  rise_i,
  input  byte_t start_data_i,
  output logic  busy_o,
  output logic  start_o,
  output logic  done_o,
  output logic  txd_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  byte_t            sh_q;
  logic             txd_q;

  assign start_o = fall_i & ~busy_q;
  assign done_o  = rise_i & busy_q & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '1;
      txd_q  <= 1'b1;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= start_data_i;
      txd_q  <= start_data_i[0];
    end else if (busy_q && fall_i) begin
      cnt_q  <= cnt_q + 1'b1;
      sh_q   <= sh_q >> 1;
      txd_q  <= sh_q[1];
    end else if (done_o) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      txd_q  <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = txd_q;
endmodule

// File: rtl/sst_buf_ctl.sv
module sst_buf_ctl
  import sst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  byte_t wr_data_i,
  input  logic  dbuf_en_i,
  input  logic  err_clr_i,
  input  logic  busy_i,
  input  logic  start_i,
  input  logic  done_i,
  output byte_t start_data_o,
  output logic  buf_empty_o,
  output logic  tx_irq_o,
  output logic  underrun_o
);
  byte_t stage_q, stage_d, hold_q, hold_d;
  logic  staged_q, staged_d, held_q, held_d;
  logic  empty_q, empty_d, irq_q, irq_d, urun_q, urun_d;

  always_comb begin
    stage_d  = stage_q;
    staged_d = staged_q;
    hold_d   = hold_q;
    held_d   = held_q;
    empty_d  = empty_q;
    irq_d    = 1'b0;
    urun_d   = urun_q;

    if (start_i) begin
      staged_d = 1'b0;
      if (!dbuf_en_i) empty_d = 1'b1;
    end

    if (done_i) begin
      if (!dbuf_en_i) begin
        irq_d = 1'b1;
      end else if (held_q) begin
        stage_d  = hold_q;
        staged_d = 1'b1;
        held_d   = 1'b0;
        empty_d  = 1'b1;
        irq_d    = 1'b1;
      end
    end

    // Writes are applied after the completion move, so a same-cycle write refills the hold
    if (wr_en_i) begin
      if (!dbuf_en_i) begin
        if (!busy_i && !start_i) begin
          stage_d  = wr_data_i;
          staged_d = 1'b1;
          empty_d  = 1'b0;
        end
      end else if (!busy_i && !staged_q && !start_i) begin
        stage_d  = wr_data_i;
        staged_d = 1'b1;
        empty_d  = 1'b1;
        irq_d    = 1'b1;
      end else begin
        hold_d  = wr_data_i;
        held_d  = 1'b1;
        empty_d = 1'b0;
      end
    end

    if (start_i && !staged_q) urun_d = 1'b1;
    else if (err_clr_i)       urun_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '1;
      staged_q <= 1'b0;
      hold_q   <= '1;
      held_q   <= 1'b0;
      empty_q  <= 1'b1;
      irq_q    <= 1'b0;
      urun_q   <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      staged_q <= staged_d;
      hold_q   <= hold_d;
      held_q   <= held_d;
      empty_q  <= empty_d;
      irq_q    <= irq_d;
      urun_q   <= urun_d;
    end
  end

  assign start_data_o = staged_q ? stage_q : FILL_BYTE;
  assign buf_empty_o  = empty_q;
  assign tx_irq_o     = irq_q;
  assign underrun_o   = urun_q;
endmodule

// File: rtl/sst_tx.sv
module sst_tx
  import sst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              dbuf_en_i,
  input  logic              err_clr_i,
  input  logic              sclk_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              tx_irq_o,
  output logic              underrun_o
);
  logic  sclk_fall, sclk_rise;
  logic  shift_busy, shift_start, shift_done;
  byte_t start_data;

  sst_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fall_o (sclk_fall),
    .rise_o (sclk_rise)
  );

  sst_shifter u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fall_i       (sclk_fall),
    .rise_i       (sclk_rise),
    .start_data_i (start_data),
    .busy_o       (shift_busy),
    .start_o      (shift_start),
    .done_o       (shift_done),
    .txd_o        (txd_o)
  );

  sst_buf_ctl u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .dbuf_en_i    (dbuf_en_i),
    .err_clr_i    (err_clr_i),
    .busy_i       (shift_busy),
    .start_i      (shift_start),
    .done_i       (shift_done),
    .start_data_o (start_data),
    .buf_empty_o  (buf_empty_o),
    .tx_irq_o     (tx_irq_o),
    .underrun_o   (underrun_o)
  );
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic dbuf_en_i,
  input logic err_clr_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic underrun_o,
  input logic busy_i,
  input logic start_i,
  input logic done_i
);
  p_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_o);

  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i);

  p_urun_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(start_i));

  p_urun_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !err_clr_i) |=> underrun_o);

  p_empty_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dbuf_en_i && !busy_i && !start_i) |=> !buf_empty_o);
endmodule

bind sst_tx sst_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .dbuf_en_i   (dbuf_en_i),
  .err_clr_i   (err_clr_i),
  .txd_o       (txd_o),
  .buf_empty_o (buf_empty_o),
  .underrun_o  (underrun_o),
  .busy_i      (shift_busy),
  .start_i     (shift_start),
  .done_i      (shift_done)
);

// File: tb/tb_sst_tx.sv
module tb_sst_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       dbuf_en_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic       sclk_i = 1'b1;
  logic       txd_o, buf_empty_o, tx_irq_o, underrun_o;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  sst_tx dut (.*);

  always @(posedge clk_i) if (tx_irq_o) irq_cnt <= irq_cnt + 1;

  // {dbuf, write, data, expected byte, expected underrun, expected irq count}
  localparam int NV = 7;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0, 2'd1},
    {1'b0, 1'b1, 8'h3C, 8'h3C, 1'b0, 2'd1},
    {1'b0, 1'b0, 8'h00, 8'hFF, 1'b1, 2'd1},
    {1'b1, 1'b1, 8'h81, 8'h81, 1'b0, 2'd1},
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 2'd0},
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 2'd1},
    {1'b0, 1'b1, 8'h6E, 8'h6E, 1'b0, 2'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    idle(3);
  endtask

  task automatic clear_err();
    @(negedge clk_i);
    err_clr_i = 1'b1;
    @(negedge clk_i);
    err_clr_i = 1'b0;
    idle(2);
  endtask

  // Drives eight sclk periods; samples txd in the low phase of each, LSB first
  task automatic run_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk_i = 1'b0;
      idle(8);
      b[i] = txd_o;
      sclk_i = 1'b1;
      idle(8);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    int base;
    idle(3);
    // R1 reset state
    chk("R1 txd", txd_o, 1);
    chk("R1 empty", buf_empty_o, 1);
    chk("R1 irq", tx_irq_o, 0);
    chk("R1 underrun", underrun_o, 0);
    rst_ni = 1'b1;
    idle(4);
    chk("R3 idle txd", txd_o, 1);

    // Table walk: R2 R4 R5 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      dbuf_en_i = VEC[v][20];
      clear_err();
      base = irq_cnt;
      if (VEC[v][19]) begin
        write_byte(VEC[v][18:11]);
        if (VEC[v][20]) chk("R5 empty after direct move", buf_empty_o, 1);
        else            chk("R9 empty cleared by write", buf_empty_o, 0);
      end
      run_byte(got);
      idle(4);
      chk(VEC[v][2] ? "R7 filler byte" : "R2 byte LSB first", got, VEC[v][10:3]);
      chk("R7 underrun flag", underrun_o, VEC[v][2]);
      chk(VEC[v][20] ? "R5 irq count" : "R4 irq count", irq_cnt - base, VEC[v][1:0]);
      chk("R3 txd high after byte", txd_o, 1);
      chk("R9 R10 empty after byte", buf_empty_o, 1);
    end

    // R6 double-buffer chain
    dbuf_en_i = 1'b1;
    clear_err();
    base = irq_cnt;
    write_byte(8'h5A);
    chk("R5 irq on direct move", irq_cnt - base, 1);
    write_byte(8'hC3);
    chk("R6 empty low while held", buf_empty_o, 0);
    chk("R6 no irq on hold", irq_cnt - base, 1);
    run_byte(got);
    idle(4);
    chk("R6 first byte", got, 8'h5A);
    chk("R6 empty after move", buf_empty_o, 1);
    chk("R6 irq on move", irq_cnt - base, 2);
    run_byte(got);
    idle(4);
    chk("R6 held byte sent next", got, 8'hC3);
    chk("R6 no irq with empty hold", irq_cnt - base, 2);
    chk("R6 no underrun", underrun_o, 0);

    // R8 sticky underrun
    run_byte(got);
    idle(40);
    chk("R7 filler after chain", got, 8'hFF);
    chk("R8 underrun sticky", underrun_o, 1);
    chk("R3 idle high", txd_o, 1);
    clear_err();
    chk("R8 underrun cleared", underrun_o, 0);

    // R10 switch back to single mode, write then send
    dbuf_en_i = 1'b0;
    base = irq_cnt;
    write_byte(8'h01);
    chk("R10 single empty low", buf_empty_o, 0);
    run_byte(got);
    idle(4);
    chk("R10 single byte", got, 8'h01);
    chk("R4 single irq", irq_cnt - base, 1);
    finish_run();
  end
endmodule